// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the shared time base for a two-channel pulse-width modulator. A 16-bit counter advances once per prescaled tick. The prescaled tick comes from a system-clock tick enable passed through two cascaded divider stages. The counter can run upward with wrap, run downward with reload, run upward and then downward, or stay frozen. The compare and action logic that sits downstream reads the counter value, a direction flag and two single-cycle event strobes. One strobe marks arrival at zero and the other marks arrival at the period value.

Software programs the block with a 16-bit control word and a 16-bit period word. The period is double-buffered. In immediate mode a period write lands in the active period on the next clock. In shadow mode the write is held in a buffer and moves to the active period only on a counter tick taken while the count is zero. The period can therefore be changed mid-cycle without producing a truncated or stretched PWM cycle.

Top module: `pwm_timebase`

## Requirements
- R1: After a synchronous active-low reset the count is 0, both strobes are low, the direction flag is 0, both divide fields are 0 and the mode is frozen, so with `tick_en` held high the count stays at 0.
- R2: Control bits 1:0 = 00 selects up mode. The count steps 0,1,…,P and then returns to 0, so one cycle takes P+1 counter ticks, and the direction flag stays 0.
- R3: Control bits 1:0 = 01 selects down mode. The count steps down to 0 and is then reloaded with P, so one cycle takes P+1 counter ticks, and the direction flag is 1.
- R4: Control bits 1:0 = 10 selects up-then-down mode. The count turns around at P and at 0, so one cycle takes 2P counter ticks. The direction flag is 1 after a downward step and 0 after an upward step.
- R5: Control bits 1:0 = 11 freezes the count and the direction flag, and no strobe fires.
- R6: Control bits 9:7 (value h) divide `tick_en` pulses by 1 when h = 0 and by 2h otherwise. Control bits 12:10 (value c) then divide by 2^c. The counter advances once per (product of both divides) `tick_en` pulses.
- R7: A clock cycle with `tick_en` low never advances the counter.
- R8: `tb_zero` is high for exactly one clock when a counter step yields 0. `tb_period` is high for exactly one clock when a counter step yields the active period. Each fires once per up-mode or down-mode cycle, and once per up-then-down cycle.
- R9: With control bit 3 = 1, a period write takes effect on the next clock. In up mode a count already above the new period returns to 0 on the next tick.
- R10: With control bit 3 = 0, a period write is held in a buffer. The buffered value becomes the active period only on a counter tick taken while the count is 0, so the cycle in progress finishes with the old period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Base tick enable fed to the prescaler |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 16 | Control word: 1:0 mode, 3 period load mode, 9:7 fine divide, 12:10 coarse divide |
| prd_wr | input | 1 | Write strobe for the period word |
| prd_wdata | input | 16 | Period value |
| tb_count | output | 16 | Current counter value |
| tb_dir_down | output | 1 | 1 when the last counter step was downward |
| tb_zero | output | 1 | One-clock strobe when a step yields 0 |
| tb_period | output | 1 | One-clock strobe when a step yields the active period |

## Verification
Table-driven runs cover each counting mode at several periods and at several prescaler settings, up to the largest product of 1792. The clock count between zero strobes separates the three cycle lengths (P+1, P+1 and 2P ticks), and it also shows whether the two divide laws are multiplied together or merely added. In the same runs the peak count, the number of period strobes and the direction flag are checked, and a run with `tick_en` toggling shows that gated cycles do not advance the counter. Directed cases cover the reset state, freezing mid-cycle, and a period reduced below the running count in both load modes. In that last case an immediate load wraps at once, while a buffered load lets the old cycle reach the old period first.

// File: rtl/pwm_timebase_pkg.sv
// Package: shared types and control-word field positions for the PWM time base.
// Assumes a 16-bit control word; the field positions are decoded by the top module.
package pwm_timebase_pkg;

    typedef enum logic [1:0] {
        CNT_UP     = 2'b00,
        CNT_DOWN   = 2'b01,
        CNT_UPDOWN = 2'b10,
        CNT_HOLD   = 2'b11
    } cnt_mode_e;

    localparam int CTL_W       = 16;
    localparam int MODE_LSB    = 0;
    localparam int LOADSEL_BIT = 3;
    localparam int FINE_LSB    = 7;
    localparam int COARSE_LSB  = 10;

endpackage

// File: rtl/pwm_tb_divstage.sv
// Module: one prescaler stage. It passes one input pulse out of every (ratio_m1+1).
// Assumes ratio_m1 may change at any time; a count already at or above the new
// limit simply fires on the next input pulse.
module pwm_tb_divstage #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_pulse,
    input  logic [CW-1:0] ratio_m1,
    output logic          out_pulse
);

    logic [CW-1:0] cnt_q;

    assign out_pulse = in_pulse && (cnt_q >= ratio_m1);

    // Count input pulses and restart on each output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (in_pulse) begin
            cnt_q <= out_pulse ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_tb_prescaler.sv
// Module: two cascaded divider stages that produce the counter tick.
// The fine stage divides by 1 or 2h and the coarse stage divides by 2^c.
// Assumes the field widths are given by DIVF_W.
module pwm_tb_prescaler #(
    parameter int DIVF_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic [DIVF_W-1:0] fine_sel,
    input  logic [DIVF_W-1:0] coarse_sel,
    output logic              tick_out
);

    localparam int FIELD_MAX = (1 << DIVF_W) - 1;
    localparam int FINE_MAX  = 2 * FIELD_MAX;
    localparam int FINE_CW   = $clog2(FINE_MAX);
    localparam int COARSE_CW = FIELD_MAX;
    localparam int TOTAL_MAX = FINE_MAX * (1 << FIELD_MAX);
    localparam int GAP_W     = $clog2(TOTAL_MAX + 1);

    logic [FINE_CW-1:0]   fine_m1;
    logic [COARSE_CW-1:0] coarse_m1;
    logic                 fine_tick;

    // Translate both select fields into terminal counts.
    always_comb begin
        fine_m1   = (fine_sel == '0) ? '0 : FINE_CW'({fine_sel, 1'b0} - 1'b1);
        coarse_m1 = COARSE_CW'((32'd1 << coarse_sel) - 32'd1);
    end

    pwm_tb_divstage #(.CW(FINE_CW)) u_fine (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_pulse (tick_in),
        .ratio_m1 (fine_m1),
        .out_pulse(fine_tick)
    );

    pwm_tb_divstage #(.CW(COARSE_CW)) u_coarse (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_pulse (fine_tick),
        .ratio_m1 (coarse_m1),
        .out_pulse(tick_out)
    );

    // Checker state: count base ticks since the last counter tick.
    logic [GAP_W-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (tick_out) begin
            gap_q <= '0;
        end else if (tick_in && gap_q < GAP_W'(TOTAL_MAX)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R6: the counter tick never lags more than the largest total divide.
    assert_gap_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_in |-> (gap_q < GAP_W'(TOTAL_MAX)));

    // R7: no counter tick in a cycle without a base tick.
    assert_tick_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_in |-> !tick_out);

endmodule

// File: rtl/pwm_tb_period.sv
// Module: double-buffered period register.
// An immediate write goes to the active value and to the buffer. A buffered write
// reaches the active value on the next load pulse, which is a counter tick at zero.
module pwm_tb_period #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         imm_load,
    input  logic         load_pulse,
    output logic [W-1:0] active_prd
);

    logic [W-1:0] shadow_q;
    logic [W-1:0] active_q;

    // Capture the written value into the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (wr_en) begin
            shadow_q <= wdata;
        end
    end

    // Update the active period, either directly or from the buffer at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (imm_load && wr_en) begin
            active_q <= wdata;
        end else if (!imm_load && load_pulse) begin
            active_q <= shadow_q;
        end
    end

    assign active_prd = active_q;

    // R10: a buffered load copies the buffer as it stood before the edge.
    assert_shadow_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_load && load_pulse) |=> (active_q == $past(shadow_q)));

    // R10: without a write or a load the active period stays unchanged.
    assert_active_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !load_pulse) |=> $stable(active_q));

    // R9: an immediate write is visible on the next clock.
    assert_imm_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_load && wr_en) |=> (active_q == $past(wdata)));

endmodule

// File: rtl/pwm_tb_counter.sv
// Module: counter core with up, down, up-then-down and hold modes.
// It steps only when `step` is high and registers the zero and period strobes
// together with the count. Assumes the period may change between steps.
module pwm_tb_counter
    import pwm_timebase_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] prd,
    output logic [W-1:0] count,
    output logic         dir_down,
    output logic         zero_hit,
    output logic         prd_hit,
    output logic         load_pulse
);

    logic [W-1:0] cnt_q, cnt_nxt;
    logic         dir_q, dir_nxt;
    logic         zero_q, prd_q;

    // Work out the next count and direction for the selected mode.
    always_comb begin
        cnt_nxt = cnt_q;
        dir_nxt = dir_q;
        unique case (mode)
            CNT_UP: begin
                dir_nxt = 1'b0;
                cnt_nxt = (cnt_q >= prd) ? '0 : cnt_q + 1'b1;
            end
            CNT_DOWN: begin
                dir_nxt = 1'b1;
                cnt_nxt = (cnt_q == '0 || cnt_q > prd) ? prd : cnt_q - 1'b1;
            end
            CNT_UPDOWN: begin
                if (prd == '0) begin
                    cnt_nxt = '0;
                end else if (!dir_q) begin
                    if (cnt_q >= prd) begin
                        cnt_nxt = cnt_q - 1'b1;
                        dir_nxt = 1'b1;
                    end else begin
                        cnt_nxt = cnt_q + 1'b1;
                    end
                end else begin
                    if (cnt_q == '0) begin
                        cnt_nxt = cnt_q + 1'b1;
                        dir_nxt = 1'b0;
                    end else begin
                        cnt_nxt = cnt_q - 1'b1;
                    end
                end
            end
            default: begin
                cnt_nxt = cnt_q;
                dir_nxt = dir_q;
            end
        endcase
    end

    // Advance the count and direction on each prescaled tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else if (step) begin
            cnt_q <= cnt_nxt;
            dir_q <= dir_nxt;
        end
    end

    // Register the one-clock event strobes in step with the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_q <= 1'b0;
            prd_q  <= 1'b0;
        end else begin
            zero_q <= step && (mode != CNT_HOLD) && (cnt_nxt == '0);
            prd_q  <= step && (mode != CNT_HOLD) && (cnt_nxt == prd);
        end
    end

    assign count      = cnt_q;
    assign dir_down   = dir_q;
    assign zero_hit   = zero_q;
    assign prd_hit    = prd_q;
    assign load_pulse = step && (cnt_q == '0);

    // R5: a frozen counter keeps its value.
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CNT_HOLD) |=> $stable(cnt_q));

    // R7: without a tick the count does not move.
    assert_no_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q));

    // R8: the zero strobe is seen only with a zero count.
    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        zero_q |-> (cnt_q == '0));

    // R2: in up mode a count at or above the period returns to zero.
    assert_up_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CNT_UP && step && cnt_q >= prd) |=> (cnt_q == '0));

    // R3: in down mode a count of zero reloads the period.
    assert_down_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CNT_DOWN && step && cnt_q == '0) |=> (cnt_q == $past(prd)));

    // R4: in up-then-down mode the direction turns upward at zero.
    assert_bottom_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CNT_UPDOWN && step && dir_q && cnt_q == '0 && prd != '0)
        |=> !dir_q);

endmodule

// File: rtl/pwm_timebase.sv
// Module: top of the PWM time base. It holds the control word and connects the
// prescaler, the period buffer and the counter core.
// Assumes a single clock domain and writes of whole words.
module pwm_timebase
    import pwm_timebase_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DIVF_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             prd_wr,
    input  logic [CNT_W-1:0] prd_wdata,
    output logic [CNT_W-1:0] tb_count,
    output logic             tb_dir_down,
    output logic             tb_zero,
    output logic             tb_period
);

    cnt_mode_e         mode_q;
    logic              imm_q;
    logic [DIVF_W-1:0] fine_q;
    logic [DIVF_W-1:0] coarse_q;
    logic              cnt_tick;
    logic              load_pulse;
    logic [CNT_W-1:0]  active_prd;
    logic              ctl_spare_unused;

    assign ctl_spare_unused = ^{ctl_wdata[CTL_W-1:COARSE_LSB+DIVF_W],
                                ctl_wdata[FINE_LSB-1:LOADSEL_BIT+1],
                                ctl_wdata[LOADSEL_BIT-1:MODE_LSB+2]};

    // Decode a control-word write into the mode, load and divide fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= CNT_HOLD;
            imm_q    <= 1'b0;
            fine_q   <= '0;
            coarse_q <= '0;
        end else if (ctl_wr) begin
            mode_q   <= cnt_mode_e'(ctl_wdata[MODE_LSB +: 2]);
            imm_q    <= ctl_wdata[LOADSEL_BIT];
            fine_q   <= ctl_wdata[FINE_LSB +: DIVF_W];
            coarse_q <= ctl_wdata[COARSE_LSB +: DIVF_W];
        end
    end

    pwm_tb_prescaler #(.DIVF_W(DIVF_W)) u_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (tick_en),
        .fine_sel  (fine_q),
        .coarse_sel(coarse_q),
        .tick_out  (cnt_tick)
    );

    pwm_tb_period #(.W(CNT_W)) u_period (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (prd_wr),
        .wdata     (prd_wdata),
        .imm_load  (imm_q),
        .load_pulse(load_pulse),
        .active_prd(active_prd)
    );

    pwm_tb_counter #(.W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (cnt_tick),
        .mode      (mode_q),
        .prd       (active_prd),
        .count     (tb_count),
        .dir_down  (tb_dir_down),
        .zero_hit  (tb_zero),
        .prd_hit   (tb_period),
        .load_pulse(load_pulse)
    );

    // R1: the first clock after reset shows a cleared, quiet counter.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tb_count == '0 && !tb_zero && !tb_period && !tb_dir_down));

endmodule

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        prd_wr = 1'b0;
    logic [15:0] prd_wdata = '0;
    logic [15:0] tb_count;
    logic        tb_dir_down, tb_zero, tb_period;

    always #2 clk = ~clk;

    pwm_timebase u_pwm_timebase (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .prd_wr(prd_wr), .prd_wdata(prd_wdata),
        .tb_count(tb_count), .tb_dir_down(tb_dir_down),
        .tb_zero(tb_zero), .tb_period(tb_period)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [2:0]  coarse;
        logic [2:0]  fine;
        logic [15:0] prd;
        logic [15:0] span;
        logic        alt;
    } vec_t;

    // mode, coarse, fine, period, expected clocks between zero strobes, toggled tick_en
    localparam vec_t VECS [10] = '{
        '{2'd0, 3'd0, 3'd0, 16'd5, 16'd6,    1'b0},
        '{2'd0, 3'd0, 3'd1, 16'd3, 16'd8,    1'b0},
        '{2'd0, 3'd1, 3'd2, 16'd2, 16'd24,   1'b0},
        '{2'd1, 3'd0, 3'd0, 16'd4, 16'd5,    1'b0},
        '{2'd2, 3'd0, 3'd0, 16'd3, 16'd6,    1'b0},
        '{2'd2, 3'd2, 3'd0, 16'd2, 16'd16,   1'b0},
        '{2'd0, 3'd0, 3'd3, 16'd1, 16'd12,   1'b0},
        '{2'd1, 3'd1, 3'd1, 16'd3, 16'd16,   1'b0},
        '{2'd0, 3'd7, 3'd7, 16'd1, 16'd3584, 1'b0},
        '{2'd0, 3'd0, 3'd0, 16'd5, 16'd12,   1'b1}
    };

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] ctl_word(input logic [1:0] mode, input logic [2:0] co,
                                             input logic [2:0] fi, input logic imm);
        return {3'b000, co, fi, 3'b000, imm, 1'b0, mode};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; tick_en = 1'b0; ctl_wr = 1'b0; prd_wr = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        ctl_wdata = v; ctl_wr = 1'b1;
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic wr_prd(input logic [15:0] v);
        prd_wdata = v; prd_wr = 1'b1;
        tick();
        prd_wr = 1'b0;
    endtask

    task automatic setup_run(input logic [1:0] mode, input logic [2:0] co,
                             input logic [2:0] fi, input logic [15:0] prd);
        do_reset();
        wr_ctl(ctl_word(2'b11, co, fi, 1'b1));
        wr_prd(prd);
        wr_ctl(ctl_word(mode, co, fi, 1'b1));
    endtask

    task automatic wait_count(input int v);
        for (int n = 0; n < 100 && tb_count != 16'(v); n++) tick();
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int v;
        int mx;

        // R1: reset state, then frozen by default with tick_en high.
        do_reset();
        check_eq("R1 count after reset", tb_count, 0);
        check_eq("R1 zero strobe after reset", tb_zero, 0);
        check_eq("R1 period strobe after reset", tb_period, 0);
        check_eq("R1 direction after reset", tb_dir_down, 0);
        tick_en = 1'b1;
        v = 0;
        for (int n = 0; n < 10; n++) begin
            tick();
            if (tb_zero || tb_count != 0) v++;
        end
        check_eq("R1 frozen after reset", v, 0);

        // Table of modes and prescale settings.
        for (int i = 0; i < 10; i++) begin
            vec_t   t;
            int     span, peak, pcnt, serr, derr, prev, wt;
            string  mtag;
            t = VECS[i];
            mtag = (t.mode == 2'd0) ? "R2" : (t.mode == 2'd1) ? "R3" : "R4";
            setup_run(t.mode, t.coarse, t.fine, t.prd);
            tick_en = 1'b1;
            wt = 0;
            while (!tb_zero && wt < 8000) begin
                tick_en = t.alt ? ~tick_en : 1'b1;
                tick(); wt++;
            end
            span = 0; peak = 0; pcnt = 0; serr = 0; derr = 0;
            prev = tb_count;
            do begin
                tick_en = t.alt ? ~tick_en : 1'b1;
                tick(); span++;
                if (tb_count > peak) peak = tb_count;
                if (tb_period) pcnt++;
                if (tb_zero && tb_count != 0) serr++;
                if (tb_period && tb_count != int'(t.prd)) serr++;
                if (t.mode == 2'd0 && tb_dir_down) derr++;
                if (t.mode == 2'd1 && !tb_dir_down) derr++;
                if (t.mode == 2'd2 && tb_count != prev && tb_dir_down != (tb_count < prev)) derr++;
                prev = tb_count;
            end while (!tb_zero && span < 8000);
            check_eq(t.alt ? "R7 span with gated ticks" : "R6 span between zero strobes",
                     span, int'(t.span));
            check_eq({mtag, " peak count"}, peak, int'(t.prd));
            check_eq("R8 period strobes per cycle", pcnt, 1);
            check_eq("R8 strobe with wrong count", serr, 0);
            check_eq({mtag, " direction flag errors"}, derr, 0);
        end

        // R5: freeze in the middle of a cycle.
        setup_run(2'b00, 3'd0, 3'd0, 16'd9);
        tick_en = 1'b1;
        wait_count(4);
        wr_ctl(ctl_word(2'b11, 3'd0, 3'd0, 1'b1));
        v = tb_count;
        mx = 0;
        for (int n = 0; n < 8; n++) begin
            tick();
            if (tb_zero || tb_period) mx++;
        end
        check_eq("R5 frozen count", tb_count, v);
        check_eq("R5 no strobe while frozen", mx, 0);

        // R7: tick_en low holds the count.
        setup_run(2'b00, 3'd0, 3'd0, 16'd9);
        tick_en = 1'b1;
        wait_count(3);
        tick_en = 1'b0;
        tick();
        v = tb_count;
        for (int n = 0; n < 6; n++) tick();
        check_eq("R7 count with tick_en low", tb_count, v);

        // R9: immediate period below the running count wraps on the next tick.
        setup_run(2'b00, 3'd0, 3'd0, 16'd9);
        tick_en = 1'b1;
        wait_count(6);
        wr_prd(16'd3);
        check_eq("R9 count at write edge", tb_count, 7);
        tick();
        check_eq("R9 wrap after immediate load", tb_count, 0);
        check_eq("R9 zero strobe on wrap", tb_zero, 1);

        // R10: buffered period waits for the counter to pass zero.
        setup_run(2'b00, 3'd0, 3'd0, 16'd9);
        tick_en = 1'b1;
        wr_ctl(ctl_word(2'b00, 3'd0, 3'd0, 1'b0));
        wait_count(5);
        wr_prd(16'd3);
        mx = tb_count;
        for (int n = 0; n < 40 && !tb_zero; n++) begin
            tick();
            if (tb_count > mx) mx = tb_count;
        end
        check_eq("R10 old period finishes", mx, 9);
        mx = 0;
        for (int n = 0; n < 40; n++) begin
            tick();
            if (tb_count > mx) mx = tb_count;
            if (tb_zero) break;
        end
        check_eq("R10 new period after zero", mx, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule